// File: doc/BRIEF.md
# Integer Execute Unit

This block is the integer execute stage of a 32-bit, three-operand load/store processor. The decoder in front of it has already chosen an operation and hands it over as a 5-bit operation code, together with the two source register values, the 16-bit constant field of the instruction, the 5-bit fixed shift count and a flag that says whether the constant stands in for the second register operand. The unit returns one 32-bit value for register write-back and a signed-overflow indication. It holds no state: the result is a purely combinational function of the inputs.

The constant is extended in one of two ways, depending on the operation. The bitwise operations zero-extend it. Add and the two set-if-less comparisons sign-extend it, and the unsigned comparison then treats the extended value as an unsigned 32-bit number. Load-upper places the constant in the upper half of the result and clears the lower half. Shifts always act on the second register operand. The fixed forms take the count from the shift field, and the variable forms take it from the low five bits of the first register operand.

The unit has no states and no transitions. The whole behaviour is a selection among the adder/comparator, the barrel shifter and the bitwise logic, keyed by the operation code.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes 0 (signed add) and 1 (unsigned add) return `a_i` plus the second operand, modulo 2^32. The second operand is `b_i` when `imm_sel_i`=0, and `imm_i` sign-extended to 32 bits when `imm_sel_i`=1.
- R2: Operation codes 2 (signed subtract) and 3 (unsigned subtract) return `a_i - b_i` modulo 2^32, and `imm_sel_i` has no effect on them.
- R3: `ovf_o` is 1 only for codes 0 and 2, and only when the two's-complement result overflows. For every other code, including 1 and 3, it is 0.
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) combine `a_i` with `b_i`, or with `imm_i` zero-extended when `imm_sel_i`=1.
- R5: Code 7 returns the bitwise NOR of `a_i` and `b_i`, and `imm_sel_i` has no effect on it.
- R6: Codes 8 (shift left logical), 9 (shift right logical) and 10 (shift right arithmetic) shift `b_i` by `shamt_i`. The arithmetic right shift fills with bit 31 of `b_i`.
- R7: Codes 11, 12 and 13 perform the same three shifts on `b_i`, but by `a_i[4:0]`. Bits 31:5 of `a_i` and the value of `shamt_i` are ignored.
- R8: Code 14 returns 1 when `a_i` is less than the second operand as signed numbers and 0 otherwise. The second operand is formed as in R1, with the constant sign-extended.
- R9: Code 15 returns 1 when `a_i` is less than the second operand as unsigned numbers and 0 otherwise. When `imm_sel_i`=1, the sign-extended constant is compared as an unsigned value.
- R10: Code 16 returns `{imm_i, 16'h0000}`, whatever the values of `a_i`, `b_i` and `imm_sel_i`.
- R11: Codes 17 to 31 are unused. They return 0 with `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Decoded operation code (see R1 to R11) |
| imm_sel_i | input | 1 | 1 selects the extended constant as second operand where the operation has a constant form |
| a_i | input | 32 | First source register value; also the count source for variable shifts |
| b_i | input | 32 | Second source register value; the value shifted by all shifts |
| imm_i | input | 16 | Constant field of the instruction |
| shamt_i | input | 5 | Fixed shift count field |
| result_o | output | 32 | Write-back value |
| ovf_o | output | 1 | Signed overflow of signed add or subtract |

## Verification
The add and subtract cases use operand pairs that sit exactly on the signed limits. These show whether overflow is detected for the signed codes and suppressed for the unsigned codes, which return the same sum. The constant cases use values with bit 15 set, which exposes any mix-up between zero extension (bitwise operations) and sign extension (add and the comparisons). The comparison cases include a pair whose difference overflows, which catches a less-than taken from the raw sign bit. The shift cases use counts of 0, 4, 30 and 31, a sweep over every count, and count registers with nonzero upper bits; together they separate the fill rules and confirm which count source each form uses.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned IMMW  = 16;
    localparam int unsigned SHW   = $clog2(XLEN);
    localparam int unsigned OPW   = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLL  = 5'd8,
        OP_SRL  = 5'd9,
        OP_SRA  = 5'd10,
        OP_SLLV = 5'd11,
        OP_SRLV = 5'd12,
        OP_SRAV = 5'd13,
        OP_SLT  = 5'd14,
        OP_SLTU = 5'd15,
        OP_LUI  = 5'd16
    } iexu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } iexu_shmode_e;

    // Operations that accept the constant in place of the second register
    function automatic logic op_has_imm(input logic [OPW-1:0] op);
        return (op == OP_ADD)  || (op == OP_ADDU) || (op == OP_AND) ||
               (op == OP_OR)   || (op == OP_XOR)  || (op == OP_SLT) ||
               (op == OP_SLTU);
    endfunction

    // Bitwise operations zero-extend their constant; the rest sign-extend
    function automatic logic op_imm_zext(input logic [OPW-1:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/iexu_opnd_sel.sv
module iexu_opnd_sel
    import iexu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IMMW
) (
    input  logic [OPW-1:0] op_i,
    input  logic           imm_sel_i,
    input  logic [W-1:0]   reg_i,
    input  logic [IW-1:0]  imm_i,
    output logic [W-1:0]   opnd_o
);
    localparam int unsigned PADW = W - IW;

    logic [W-1:0] imm_ext;
    logic         fill_bit;

    always_comb begin
        fill_bit = op_imm_zext(op_i) ? 1'b0 : imm_i[IW-1];
        imm_ext  = {{PADW{fill_bit}}, imm_i};
        opnd_o   = (imm_sel_i && op_has_imm(op_i)) ? imm_ext : reg_i;
    end

endmodule

// File: rtl/iexu_addsub.sv
module iexu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] b_inv;
    logic [W:0]   wide;

    always_comb begin
        b_inv  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_inv} + {{W{1'b0}}, sub_i};
        sum_o  = wide[W-1:0];
        // Two's-complement overflow: equal input signs, different result sign
        ovf_o  = (a_i[MSB] == b_inv[MSB]) && (sum_o[MSB] != a_i[MSB]);
        // Signed less-than from the difference, corrected for overflow
        lt_s_o = sum_o[MSB] ^ ovf_o;
        // Unsigned less-than is the borrow of the subtraction
        lt_u_o = ~wide[W];
    end

endmodule

// File: rtl/iexu_shifter.sv
module iexu_shifter
    import iexu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]   val_i,
    input  logic [SW-1:0]  amt_i,
    input  iexu_shmode_e   mode_i,
    output logic [W-1:0]   res_o
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = val_i;

    // One stage per count bit; stage k moves by 2**k positions
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int unsigned DIST = 1 << k;
        logic [W-1:0] moved;
        always_comb begin
            unique case (mode_i)
                SH_LEFT: moved = stage[k] << DIST;
                SH_RLOG: moved = stage[k] >> DIST;
                SH_RARI: moved = W'($signed(stage[k]) >>> DIST);
                default: moved = stage[k];
            endcase
        end
        assign stage[k+1] = amt_i[k] ? moved : stage[k];
    end

    assign res_o = stage[SW];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IMMW,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [OPW-1:0] op_i,
    input  logic           imm_sel_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [IW-1:0]  imm_i,
    input  logic [SW-1:0]  shamt_i,
    output logic [W-1:0]   result_o,
    output logic           ovf_o
);
    localparam int unsigned LOW_CLR = W - IW;

    iexu_op_e     op_e;
    logic [W-1:0] opnd_b;
    logic         do_sub;
    logic [W-1:0] sum;
    logic         add_ovf;
    logic         lt_s;
    logic         lt_u;
    logic [SW-1:0] sh_amt;
    iexu_shmode_e sh_mode;
    logic [W-1:0] sh_res;

    assign op_e = iexu_op_e'(op_i);

    // Second operand: register or extended constant (R1, R4, R8, R9)
    iexu_opnd_sel #(.W(W), .IW(IW)) u_opnd (
        .op_i      (op_i),
        .imm_sel_i (imm_sel_i),
        .reg_i     (b_i),
        .imm_i     (imm_i),
        .opnd_o    (opnd_b)
    );

    // Subtract for the subtract codes and both comparisons
    always_comb begin
        unique case (op_e)
            OP_SUB, OP_SUBU, OP_SLT, OP_SLTU: do_sub = 1'b1;
            default:                          do_sub = 1'b0;
        endcase
    end

    iexu_addsub #(.W(W)) u_addsub (
        .a_i    (a_i),
        .b_i    (opnd_b),
        .sub_i  (do_sub),
        .sum_o  (sum),
        .ovf_o  (add_ovf),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    // Shift count source and direction (R6, R7)
    always_comb begin
        unique case (op_e)
            OP_SLLV, OP_SRLV, OP_SRAV: sh_amt = a_i[SW-1:0];
            default:                   sh_amt = shamt_i;
        endcase
        unique case (op_e)
            OP_SRL, OP_SRLV: sh_mode = SH_RLOG;
            OP_SRA, OP_SRAV: sh_mode = SH_RARI;
            default:         sh_mode = SH_LEFT;
        endcase
    end

    iexu_shifter #(.W(W), .SW(SW)) u_shift (
        .val_i  (b_i),
        .amt_i  (sh_amt),
        .mode_i (sh_mode),
        .res_o  (sh_res)
    );

    // Result selection
    always_comb begin
        result_o = '0;
        ovf_o    = 1'b0;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                result_o = sum;
                ovf_o    = add_ovf;
            end
            OP_ADDU, OP_SUBU:          result_o = sum;
            OP_AND:                    result_o = a_i & opnd_b;
            OP_OR:                     result_o = a_i | opnd_b;
            OP_XOR:                    result_o = a_i ^ opnd_b;
            OP_NOR:                    result_o = ~(a_i | b_i);
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV: result_o = sh_res;
            OP_SLT:                    result_o = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:                   result_o = {{(W-1){1'b0}}, lt_u};
            OP_LUI:                    result_o = {imm_i, {LOW_CLR{1'b0}}};
            default: begin
                result_o = '0;         // R11 unused codes
                ovf_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
    import iexu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IMMW,
    parameter int unsigned SW = $clog2(W)
) (
    input logic [OPW-1:0] op_i,
    input logic           imm_sel_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic [IW-1:0]  imm_i,
    input logic [SW-1:0]  shamt_i,
    input logic [W-1:0]   result_o,
    input logic           ovf_o
);
    localparam int unsigned LOW_CLR = W - IW;

    always_comb begin
        if (op_i != OP_ADD && op_i != OP_SUB)
            AST_NO_OVERFLOW: assert (!ovf_o) else $error("overflow on non-signed op"); // R3
        if (op_i == OP_LUI)
            AST_LUI_LOW_CLEAR: assert (result_o[LOW_CLR-1:0] == '0) else $error("upper-load low half"); // R10
        if (op_i == OP_SLT)
            AST_SLT_BOOL: assert (result_o[W-1:1] == '0) else $error("signed compare not 0/1"); // R8
        if (op_i == OP_SLTU)
            AST_SLTU_BOOL: assert (result_o[W-1:1] == '0) else $error("unsigned compare not 0/1"); // R9
        if (op_i == OP_AND && imm_sel_i)
            AST_AND_IMM_ZEXT: assert (result_o[W-1:IW] == '0) else $error("and-constant upper bits"); // R4
        if ((op_i == OP_SRA || op_i == OP_SRAV) && b_i[W-1])
            AST_SRA_SIGN_FILL: assert (result_o[W-1]) else $error("arithmetic shift lost sign"); // R6
        if (op_i > OP_LUI)
            AST_UNUSED_ZERO: assert (result_o == '0 && !ovf_o) else $error("unused code output"); // R11
    end

endmodule

bind int_exec_unit int_exec_unit_chk #(.W(W), .IW(IW), .SW(SW)) u_chk (
    .op_i      (op_i),
    .imm_sel_i (imm_sel_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .shamt_i   (shamt_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op;
    logic        sel;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic [31:0] res;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    int_exec_unit dut (
        .op_i(op), .imm_sel_i(sel), .a_i(a), .b_i(b),
        .imm_i(imm), .shamt_i(sh), .result_o(res), .ovf_o(ovf)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic        sel;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] exp;
        logic        ov;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0,  32'h8000_0000, 1'b1, 4'd3},  // R3
        '{5'd0,  1'b0, 32'h0000_1234, 32'h0000_0005, 16'h0000, 5'd0,  32'h0000_1239, 1'b0, 4'd1},  // R1
        '{5'd0,  1'b1, 32'h0000_0010, 32'hDEAD_BEEF, 16'hFFFF, 5'd0,  32'h0000_000F, 1'b0, 4'd1},  // R1
        '{5'd0,  1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0000, 5'd0,  32'h7FFF_FFFF, 1'b1, 4'd3},  // R3
        '{5'd1,  1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0,  32'h8000_0000, 1'b0, 4'd3},  // R3
        '{5'd0,  1'b1, 32'h7FFF_FFF0, 32'h0000_0000, 16'h0010, 5'd0,  32'h8000_0000, 1'b1, 4'd3},  // R3
        '{5'd2,  1'b0, 32'h0000_0005, 32'h0000_0007, 16'h0000, 5'd0,  32'hFFFF_FFFE, 1'b0, 4'd2},  // R2
        '{5'd2,  1'b0, 32'h8000_0000, 32'h0000_0001, 16'h0000, 5'd0,  32'h7FFF_FFFF, 1'b1, 4'd3},  // R3
        '{5'd3,  1'b0, 32'h0000_0000, 32'h0000_0001, 16'h0000, 5'd0,  32'hFFFF_FFFF, 1'b0, 4'd3},  // R3
        '{5'd2,  1'b1, 32'h0000_0009, 32'h0000_0004, 16'hFFFF, 5'd0,  32'h0000_0005, 1'b0, 4'd2},  // R2
        '{5'd4,  1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 5'd0,  32'hF000_F000, 1'b0, 4'd4},  // R4
        '{5'd4,  1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h8001, 5'd0,  32'h0000_8001, 1'b0, 4'd4},  // R4
        '{5'd5,  1'b1, 32'h1234_0000, 32'h0000_0000, 16'h8000, 5'd0,  32'h1234_8000, 1'b0, 4'd4},  // R4
        '{5'd6,  1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h00FF, 5'd0,  32'hFFFF_FF00, 1'b0, 4'd4},  // R4
        '{5'd6,  1'b0, 32'hAAAA_AAAA, 32'hFFFF_0000, 16'h0000, 5'd0,  32'h5555_AAAA, 1'b0, 4'd4},  // R4
        '{5'd7,  1'b0, 32'hF0F0_0000, 32'h0F00_00FF, 16'h0000, 5'd0,  32'h000F_FF00, 1'b0, 4'd5},  // R5
        '{5'd7,  1'b1, 32'h0000_0000, 32'h0000_0000, 16'hFFFF, 5'd0,  32'hFFFF_FFFF, 1'b0, 4'd5},  // R5
        '{5'd8,  1'b0, 32'h0000_0000, 32'h0000_0001, 16'h0000, 5'd31, 32'h8000_0000, 1'b0, 4'd6},  // R6
        '{5'd9,  1'b0, 32'h0000_0000, 32'h8000_0000, 16'h0000, 5'd4,  32'h0800_0000, 1'b0, 4'd6},  // R6
        '{5'd10, 1'b0, 32'h0000_0000, 32'h8000_0000, 16'h0000, 5'd4,  32'hF800_0000, 1'b0, 4'd6},  // R6
        '{5'd10, 1'b0, 32'h0000_0000, 32'h4000_0000, 16'h0000, 5'd30, 32'h0000_0001, 1'b0, 4'd6},  // R6
        '{5'd11, 1'b0, 32'hFFFF_FFE3, 32'h0000_0011, 16'h0000, 5'd31, 32'h0000_0088, 1'b0, 4'd7},  // R7
        '{5'd12, 1'b0, 32'h0000_0024, 32'hF000_0000, 16'h0000, 5'd0,  32'h0F00_0000, 1'b0, 4'd7},  // R7
        '{5'd13, 1'b0, 32'h0000_003F, 32'h8000_0000, 16'h0000, 5'd0,  32'hFFFF_FFFF, 1'b0, 4'd7},  // R7
        '{5'd14, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0,  32'h0000_0001, 1'b0, 4'd8},  // R8
        '{5'd14, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0000, 5'd0,  32'h0000_0000, 1'b0, 4'd8},  // R8
        '{5'd14, 1'b1, 32'hFFFF_FFFE, 32'h0000_0000, 16'hFFFF, 5'd0,  32'h0000_0001, 1'b0, 4'd8},  // R8
        '{5'd14, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 5'd0,  32'h0000_0001, 1'b0, 4'd8},  // R8
        '{5'd15, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0,  32'h0000_0000, 1'b0, 4'd9},  // R9
        '{5'd15, 1'b1, 32'h0000_1000, 32'h0000_0000, 16'h8000, 5'd0,  32'h0000_0001, 1'b0, 4'd9},  // R9
        '{5'd15, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 5'd0,  32'h0000_0000, 1'b0, 4'd9},  // R9
        '{5'd16, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 5'd0,  32'hABCD_0000, 1'b0, 4'd10}, // R10
        '{5'd16, 1'b1, 32'h1234_5678, 32'h0000_0000, 16'h0001, 5'd0,  32'h0001_0000, 1'b0, 4'd10}, // R10
        '{5'd17, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd5,  32'h0000_0000, 1'b0, 4'd11}, // R11
        '{5'd31, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 16'hFFFF, 5'd0,  32'h0000_0000, 1'b0, 4'd11}  // R11
    };

    task automatic apply(input logic [4:0] o, input logic s, input logic [31:0] va,
                         input logic [31:0] vb, input logic [15:0] vi, input logic [4:0] vs);
        @(posedge clk);
        op = o; sel = s; a = va; b = vb; imm = vi; sh = vs;
        @(negedge clk);
    endtask

    task automatic check(input int rq, input logic [31:0] exp, input logic exp_ov);
        n_chk++;
        if (res !== exp || ovf !== exp_ov) begin
            n_bad++;
            $display("FAIL R%0d op=%0d result=%h ovf=%b expected result=%h ovf=%b",
                     rq, op, res, ovf, exp, exp_ov);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        op = '0; sel = 1'b0; a = '0; b = '0; imm = '0; sh = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle-state check: all-zero inputs select add of zeros (R1, R3)
        check(1, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].sel, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
            check(int'(VECS[i].rq), VECS[i].exp, VECS[i].ov);
        end

        // R6: sweep of every fixed count, left and logical right
        for (int k = 0; k < 32; k++) begin
            apply(5'd8, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'(k));
            check(6, 32'h0000_0001 << k, 1'b0);
            apply(5'd9, 1'b0, 32'h0, 32'h8000_0000, 16'h0, 5'(k));
            check(6, 32'h8000_0000 >> k, 1'b0);
        end

        // R7: variable shift ignores upper bits of the count register and shamt
        for (int k = 0; k < 32; k++) begin
            apply(5'd13, 1'b1, {27'h5A5A5A5, 5'(k)}, 32'h8000_0001, 16'hFFFF, 5'(31 - k));
            check(7, 32'($signed(32'h8000_0001) >>> k), 1'b0);
        end

        // R3: unsigned subtract at the signed limit keeps overflow low
        apply(5'd3, 1'b0, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0);
        check(3, 32'h7FFF_FFFF, 1'b0);
        // R1: unsigned add with a negative constant wraps, no overflow
        apply(5'd1, 1'b1, 32'h0000_0000, 32'h0, 16'h8000, 5'd0);
        check(1, 32'hFFFF_8000, 1'b0);
        // R5: NOR with select set uses b, not the constant
        apply(5'd7, 1'b1, 32'h0000_0000, 32'hFFFF_0000, 16'h1234, 5'd0);
        check(5, 32'h0000_FFFF, 1'b0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule